// File: doc/BRIEF.md
# Indexed RTC Register Port

This block is the host-facing register front end of a real-time clock. A host reaches 128 byte registers through two addresses. A write to the even address picks a register index. An access to the odd address then reads or writes the register that index points at. Four of the indices hold the control registers:

- A holds the divider and rate settings and shows a live update-in-progress bit.
- B holds the interrupt enables and the mode bits.
- C holds the event flags and the interrupt summary bit.
- D is a constant status byte.

All other indices are plain byte storage.

The time counter and the alarm comparator sit outside this block. When the host writes one of the time or alarm bytes, the block raises a same-cycle load strobe carrying the index and the data. The outside counter reports three things back: update-ended pulses, alarm-match pulses and periodic pulses, plus the level of its update-in-progress flag. The block turns these pulses into flags in register C and drives a single active-high interrupt request.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address (bus_addr = 0) loads the index from data bits 6:0. A read of the even address returns 0xFF.
- R2: An odd-address access reads or writes the indexed register. Indices 14 to 127 and 0 to 9 keep the last byte written. A write to an index below 10 also pulses tm_load_o in the same cycle, with tm_idx_o and tm_data_o carrying the index and the data.
- R3: After rst_n, register A (index 10) reads 0x26, B (index 11) reads 0x02, C (index 12) reads 0x00, D (index 13) reads 0x80, and irq_o is 0.
- R4: Writes to register C and register D change nothing.
- R5: Register C holds IRQF in bit 7, PF in bit 6, AF in bit 5 and UF in bit 4. Reading C returns its current value, then clears all of C and drops irq_o. An event arriving in the same cycle as that read is kept.
- R6: An event that sets a flag previously clear, while the enable bit in B at the same position is 1, sets IRQF and raises irq_o on the next cycle. The enables are PIE in bit 6, AIE in bit 5 and UIE in bit 4.
- R7: A write to B whose new enables cover a flag already pending sets IRQF and raises irq_o at once. Any other write to B clears IRQF and drops irq_o.
- R8: A write to B with bit 7 (SET) = 1 stores bit 4 (UIE) as 0.
- R9: A periodic pulse always sets PF. It sets IRQF only when PIE is 1.
- R10: A soft_rst_i cycle clears bits 6, 5 and 3 of B, clears all of C and drops irq_o. The other bits of B are kept.
- R11: Reading A returns uip_i in bit 7 and the stored bits 6:0. The host cannot write bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst_i | input | 1 | Synchronous system reset of the enables and flags |
| bus_sel | input | 1 | Host access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid in the access cycle |
| uip_i | input | 1 | Live update-in-progress level from the time counter |
| ev_update_i | input | 1 | Update-ended pulse |
| ev_alarm_i | input | 1 | Alarm-match pulse |
| ev_periodic_i | input | 1 | Periodic-rate pulse |
| tm_load_o | output | 1 | Time or alarm byte write strobe |
| tm_idx_o | output | 7 | Index of the byte being loaded |
| tm_data_o | output | 8 | Value of the byte being loaded |
| irq_o | output | 1 | Interrupt request, equal to IRQF |

## Verification
Read data and the load strobe are combinational, so they are due in the same cycle as the access. The bench samples them 1 ns after it drives the access, before the clock edge that ends it. Flag, enable and interrupt changes are registered, so they are due one edge after the event pulse, the B write or the soft reset. The bench checks them at the falling edge that follows. Each read of C returns the value held before its own clearing edge, and the bench's expected values are modelled on that ordering.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int TIME_BYTES = 10;

  localparam logic [IDX_W-1:0] IDX_CTL_A = 7'd10;
  localparam logic [IDX_W-1:0] IDX_CTL_B = 7'd11;
  localparam logic [IDX_W-1:0] IDX_CTL_C = 7'd12;
  localparam logic [IDX_W-1:0] IDX_CTL_D = 7'd13;

  localparam logic [DATA_W-1:0] CTL_A_RST = 8'h26;
  localparam logic [DATA_W-1:0] CTL_B_RST = 8'h02;
  localparam logic [DATA_W-1:0] CTL_D_VAL = 8'h80;
  localparam logic [DATA_W-1:0] SOFT_B_CLR = 8'h68;

  localparam int BIT_SET = 7;
  localparam int BIT_UIE = 4;

  // Value kept when the host writes register B: the freeze bit masks the update enable.
  function automatic logic [DATA_W-1:0] b_store(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    if (d[BIT_SET]) r[BIT_UIE] = 1'b0;
    return r;
  endfunction

  // Summary bit after an enable write: set if any enabled flag is pending.
  function automatic logic pending_hit(input logic [2:0] en, input logic [2:0] flags);
    return |(en & flags);
  endfunction

  // Sources that raise the summary bit on this event cycle.
  // Order of bits: {periodic, alarm, update}.
  function automatic logic [2:0] event_hit(input logic [2:0] ev, input logic [2:0] old,
                                           input logic [2:0] en);
    logic [2:0] h;
    h = ev & ~old & en;
    h[2] = ev[2] & en[2];
    return h;
  endfunction
endpackage

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-2:0] a_q,
  output logic [DATA_W-1:0] b_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= CTL_A_RST[DATA_W-2:0];
      b_q <= CTL_B_RST;
    end else if (soft_rst) begin
      b_q <= b_q & ~SOFT_B_CLR;
    end else begin
      if (wr_a) a_q <= wdata[DATA_W-2:0];
      if (wr_b) b_q <= b_store(wdata);
    end
  end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_regport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       rd_clear,
  input  logic       b_wr,
  input  logic [2:0] b_wen,
  input  logic [2:0] en,
  input  logic [2:0] ev,
  output logic [2:0] flags_q,
  output logic       irqf_q
);
  logic [2:0] flags_base, en_eff, hit;
  logic       irqf_base;

  always_comb begin
    flags_base = rd_clear ? 3'b000 : flags_q;
    irqf_base  = rd_clear ? 1'b0 : irqf_q;
    en_eff     = b_wr ? b_wen : en;
    if (b_wr) irqf_base = pending_hit(b_wen, flags_base);
    hit = event_hit(ev, flags_base, en_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irqf_q  <= 1'b0;
    end else if (soft_rst) begin
      flags_q <= '0;
      irqf_q  <= 1'b0;
    end else begin
      flags_q <= flags_base | ev;
      irqf_q  <= irqf_base | (|hit);
    end
  end
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              uip_i,
  input  logic              ev_update_i,
  input  logic              ev_alarm_i,
  input  logic              ev_periodic_i,
  output logic              tm_load_o,
  output logic [IDX_W-1:0]  tm_idx_o,
  output logic [DATA_W-1:0] tm_data_o,
  output logic              irq_o
);
  logic [IDX_W-1:0]  idx_q;
  logic              idx_wr, data_wr, data_rd;
  logic              is_ctl, wr_a, wr_b, rd_c, ram_we;
  logic [DATA_W-2:0] a_q;
  logic [DATA_W-1:0] b_q, c_q, ram_rd, b_next;
  logic [2:0]        flags_q, ev_vec;
  logic              irqf_q;

  assign idx_wr  = bus_sel & bus_wr & ~bus_addr;
  assign data_wr = bus_sel & bus_wr & bus_addr;
  assign data_rd = bus_sel & ~bus_wr & bus_addr;
  assign is_ctl  = (idx_q >= IDX_CTL_A) && (idx_q <= IDX_CTL_D);
  assign wr_a    = data_wr && idx_q == IDX_CTL_A;
  assign wr_b    = data_wr && idx_q == IDX_CTL_B;
  assign rd_c    = data_rd && idx_q == IDX_CTL_C;
  assign ram_we  = data_wr && !is_ctl;
  assign ev_vec  = {ev_periodic_i, ev_alarm_i, ev_update_i};
  assign b_next  = b_store(bus_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_wr) idx_q <= bus_wdata[IDX_W-1:0];
  end

  rtc_byte_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) ram_i (
    .clk(clk), .we(ram_we), .addr(idx_q), .wdata(bus_wdata), .rdata(ram_rd)
  );

  rtc_ctrl_regs ctrl_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i), .wr_a(wr_a), .wr_b(wr_b),
    .wdata(bus_wdata), .a_q(a_q), .b_q(b_q)
  );

  rtc_flag_unit flag_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i), .rd_clear(rd_c),
    .b_wr(wr_b), .b_wen(b_next[6:4]), .en(b_q[6:4]), .ev(ev_vec),
    .flags_q(flags_q), .irqf_q(irqf_q)
  );

  assign c_q   = {irqf_q, flags_q, 4'b0000};
  assign irq_o = irqf_q;

  always_comb begin
    if (!bus_addr) begin
      bus_rdata = 8'hFF;
    end else begin
      unique case (idx_q)
        IDX_CTL_A: bus_rdata = {uip_i, a_q};
        IDX_CTL_B: bus_rdata = b_q;
        IDX_CTL_C: bus_rdata = c_q;
        IDX_CTL_D: bus_rdata = CTL_D_VAL;
        default:   bus_rdata = ram_rd;
      endcase
    end
  end

  assign tm_load_o = data_wr && (int'(idx_q) < TIME_BYTES);
  assign tm_idx_o  = idx_q;
  assign tm_data_o = bus_wdata;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk
  import rtc_regport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst_i,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [2:0]        ev_vec,
  input logic [IDX_W-1:0]  idx_q,
  input logic [DATA_W-1:0] b_q,
  input logic [DATA_W-1:0] c_q,
  input logic              irq_o
);
  logic odd_wr, odd_rd;
  assign odd_wr = bus_sel & bus_wr & bus_addr;
  assign odd_rd = bus_sel & ~bus_wr & bus_addr;

  assert_even_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !bus_addr) |-> bus_rdata == 8'hFF);

  assert_cd_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_wr && (idx_q == IDX_CTL_C || idx_q == IDX_CTL_D) && ev_vec == 3'b000
     && !soft_rst_i) |=> $stable(c_q));

  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_rd && idx_q == IDX_CTL_C && ev_vec == 3'b000 && !soft_rst_i)
    |=> (c_q == 8'h00 && !irq_o));

  assert_set_masks_uie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_wr && idx_q == IDX_CTL_B && bus_wdata[BIT_SET] && !soft_rst_i) |=> !b_q[BIT_UIE]);

  assert_periodic_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec[2] && b_q[6] && !soft_rst_i && !(odd_wr && idx_q == IDX_CTL_B))
    |=> (irq_o && c_q[6]));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!irq_o && c_q == 8'h00 && (b_q & SOFT_B_CLR) == 8'h00));
endmodule

bind rtc_regport rtc_regport_chk chk_i (
  .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .ev_vec(ev_vec), .idx_q(idx_q), .b_q(b_q),
  .c_q(c_q), .irq_o(irq_o)
);

// File: tb/rtc_regport_tb_top.sv
module rtc_regport_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst_i = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic uip_i = 1'b0;
  logic ev_update_i = 1'b0, ev_alarm_i = 1'b0, ev_periodic_i = 1'b0;
  logic tm_load_o;
  logic [6:0] tm_idx_o;
  logic [7:0] tm_data_o;
  logic irq_o;

  int checks = 0, fails = 0;
  logic [7:0] got;
  logic got_ld;
  logic [6:0] got_ldi;
  logic [7:0] got_ldd;

  always #10 clk = ~clk;

  rtc_regport dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .uip_i(uip_i), .ev_update_i(ev_update_i),
    .ev_alarm_i(ev_alarm_i), .ev_periodic_i(ev_periodic_i),
    .tm_load_o(tm_load_o), .tm_idx_o(tm_idx_o), .tm_data_o(tm_data_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One bus cycle, started at a falling edge; sampling 1 ns after drive.
  task automatic acc(input logic wr, input logic a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    got = bus_rdata; got_ld = tm_load_o; got_ldi = tm_idx_o; got_ldd = tm_data_o;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [6:0] i, input logic [7:0] d);
    acc(1'b1, 1'b0, {1'b0, i});
    acc(1'b1, 1'b1, d);
  endtask

  task automatic rd_reg(input logic [6:0] i);
    acc(1'b1, 1'b0, {1'b0, i});
    acc(1'b0, 1'b1, 8'h00);
  endtask

  // Pulse {periodic, alarm, update} for one cycle.
  task automatic pulse(input logic [2:0] v);
    {ev_periodic_i, ev_alarm_i, ev_update_i} = v;
    @(posedge clk); @(negedge clk);
    {ev_periodic_i, ev_alarm_i, ev_update_i} = 3'b000;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] expv;
    logic irqf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset values
    chk("R3 irq", irq_o, 0);
    rd_reg(7'd10); chk("R3 A", got, 8'h26);
    rd_reg(7'd11); chk("R3 B", got, 8'h02);
    rd_reg(7'd12); chk("R3 C", got, 8'h00);
    rd_reg(7'd13); chk("R3 D", got, 8'h80);

    // R1 even-address read
    acc(1'b0, 1'b0, 8'h00); chk("R1 even read", got, 8'hFF);
    // R1 index uses only bits 6:0: 0x8E selects index 14
    wr_reg(7'd14, 8'h3C);
    acc(1'b1, 1'b0, 8'h8E); acc(1'b0, 1'b1, 8'h00); chk("R1 index bit7 dropped", got, 8'h3C);

    // R2 plain bytes sweep
    for (int i = 14; i < 128; i++) wr_reg(7'(i), 8'((i * 7 + 3) ^ 8'h5A));
    for (int i = 14; i < 128; i++) begin
      rd_reg(7'(i)); chk("R2 ram readback", got, 8'((i * 7 + 3) ^ 8'h5A));
    end
    // R2 time bytes with load strobe
    for (int i = 0; i < 10; i++) begin
      wr_reg(7'(i), 8'(i * 16 + 9));
      chk("R2 load strobe", got_ld, 1);
      chk("R2 load idx", got_ldi, i);
      chk("R2 load data", got_ldd, i * 16 + 9);
    end
    for (int i = 0; i < 10; i++) begin
      rd_reg(7'(i)); chk("R2 time readback", got, i * 16 + 9);
    end
    wr_reg(7'd20, 8'h11); chk("R2 no strobe above time bytes", got_ld, 0);

    // R11 UIP in bit 7 of A
    wr_reg(7'd10, 8'hA5);
    uip_i = 1'b1; rd_reg(7'd10); chk("R11 A uip=1", got, 8'hA5);
    uip_i = 1'b0; rd_reg(7'd10); chk("R11 A uip=0", got, 8'h25);

    // R4 D ignores writes
    wr_reg(7'd13, 8'h00); rd_reg(7'd13); chk("R4 D write ignored", got, 8'h80);

    // R6/R9 sweep: enables x events
    for (int e = 0; e < 8; e++) begin
      for (int v = 0; v < 8; v++) begin
        wr_reg(7'd11, {1'b0, 3'(e), 4'b0010});
        rd_reg(7'd12);
        pulse(3'(v));
        irqf = |(3'(e) & 3'(v));
        chk("R6 irq after event", irq_o, irqf);
        rd_reg(7'd12);
        expv = {irqf, 3'(v), 4'b0000};
        chk("R5 C value", got, expv);
        chk("R5 irq after read", irq_o, 0);
        rd_reg(7'd12); chk("R5 C cleared", got, 8'h00);
      end
    end

    // R9 periodic with PIE off sets only PF; R4 C ignores writes
    wr_reg(7'd11, 8'h02); rd_reg(7'd12);
    pulse(3'b100);
    chk("R9 no irq when PIE=0", irq_o, 0);
    wr_reg(7'd12, 8'hFF);
    chk("R4 irq after C write", irq_o, 0);
    rd_reg(7'd12); chk("R4/R9 C after write", got, 8'h40);

    // R7 pending then enable, then a non-covering enable
    for (int f = 0; f < 3; f++) begin
      wr_reg(7'd11, 8'h02); rd_reg(7'd12);
      pulse(3'(1 << f));
      chk("R7 pending no irq", irq_o, 0);
      wr_reg(7'd11, 8'(8'h02 | (8'h10 << f)));
      chk("R7 irq on enable", irq_o, 1);
      wr_reg(7'd11, 8'(8'h02 | (8'h10 << ((f + 1) % 3))));
      chk("R7 irq cleared by other enable", irq_o, 0);
      rd_reg(7'd12); chk("R7 C", got, 8'(8'h10 << f));
    end

    // R5 event in same cycle as the read of C is kept
    wr_reg(7'd11, 8'h22); rd_reg(7'd12);
    pulse(3'b001);
    acc(1'b1, 1'b0, 8'd12);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1; ev_alarm_i = 1'b1;
    #1 got = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; ev_alarm_i = 1'b0;
    chk("R5 read returns old C", got, 8'h10);
    chk("R5 same-cycle event irq", irq_o, 1);
    rd_reg(7'd12); chk("R5 same-cycle event kept", got, 8'hA0);

    // R8 SET masks UIE
    wr_reg(7'd11, 8'hF2); rd_reg(7'd11); chk("R8 B with SET", got, 8'hE2);
    wr_reg(7'd11, 8'h72); rd_reg(7'd11); chk("R8 B without SET", got, 8'h72);

    // R10 soft reset
    wr_reg(7'd11, 8'h7A); rd_reg(7'd12);
    pulse(3'b110);
    chk("R10 irq before", irq_o, 1);
    soft_rst_i = 1'b1; @(posedge clk); @(negedge clk); soft_rst_i = 1'b0;
    chk("R10 irq after", irq_o, 0);
    rd_reg(7'd11); chk("R10 B", got, 8'h12);
    rd_reg(7'd12); chk("R10 C", got, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule